// File: doc/BRIEF.md
# Bidirectional Timer Counter Unit

This block is the counting core of an 8-bit timer. A register holds the count. On each selected timer tick the count moves up by one, moves down by one, or returns to zero. The waveform-mode input decides which of these happens and when. Ticks come from one of seven single-cycle enable inputs, which a prescaler outside the block drives synchronously to the system clock. A 3-bit clock-select input picks one of them, or none.

Software can overwrite the count at any time through a write strobe. That write takes precedence over anything the tick would have done in the same cycle. The block reports when the count sits at its maximum and when it sits at zero. It keeps an overflow flag that software clears by writing a one to it, and an interrupt request that follows the flag when interrupts are enabled.

Top module: `tmr_count_unit`

## Requirements
- R1: While rst_n is low and on the first cycle after release, cnt_out reads 0x00, ovf_flag reads 0, irq reads 0, and the internal direction is upward.
- R2: clk_sel = 0 selects no tick, so the count holds. clk_sel = k (1..7) makes tick_src[k-1] the tick, and the other tick_src bits have no effect.
- R3: In free-running mode (wave_mode 0, 3, 4, 6 or 7), each tick adds one to the count modulo 256. A tick taken while the count is 0xFF sets the overflow flag.
- R4: In clear-on-match mode (wave_mode 2), a tick taken while the count equals cmp_val loads 0x00. Otherwise the tick adds one modulo 256. A tick taken while the count is 0xFF sets the overflow flag.
- R5: In up/down mode with a fixed top (wave_mode 1), the count rises to 0xFF and then falls to 0x00. Direction turns on the tick taken at 0xFF and again on the tick taken at 0x00. Leaving modes 1 and 5 resets the direction to upward.
- R6: In up/down mode with a programmable top (wave_mode 5), cmp_val is the turning point. A tick while counting up at or above cmp_val turns the direction downward. If cmp_val is 0x00 and the count is 0x00, ticks leave the count at 0x00.
- R7: In both up/down modes, a tick that takes the count from 0x01 down to 0x00 sets the overflow flag.
- R8: When cpu_wr_cnt is high, the next count is cpu_wdata whatever the tick would have done. In that cycle the tick's direction change and flag set are discarded.
- R9: at_top is high exactly when cnt_out is 0xFF, and at_bottom is high exactly when cnt_out is 0x00.
- R10: flag_wr with flag_wdata = 1 clears ovf_flag on the next cycle. flag_wdata = 0 has no effect. A set event in the same cycle as a clear wins.
- R11: irq equals ovf_flag AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_src | input | 7 | Candidate single-cycle tick enables |
| clk_sel | input | 3 | Tick source select, 0 = stopped |
| wave_mode | input | 3 | Counting sequence select |
| cmp_val | input | 8 | Match value / programmable top |
| cpu_wr_cnt | input | 1 | Software write strobe for the count |
| cpu_wdata | input | 8 | Value loaded by a count write |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Flag write data, 1 clears |
| irq_en | input | 1 | Interrupt enable |
| cnt_out | output | 8 | Current count |
| at_top | output | 1 | Count is 0xFF |
| at_bottom | output | 1 | Count is 0x00 |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs. Every tick_src bit is a level that is already synchronous to clk, so one high cycle means one tick. Control inputs also never change between clock edges in a way that matters. The stimulus meets both by driving every input on the falling edge from one process. Tick bits are drawn afresh each cycle, so back-to-back ticks and gaps both occur. Across the sweeps, mode and select change only between runs, while count writes and flag writes are scattered freely, including on tick cycles.

// File: rtl/tmr_pkg.sv
// Shared mode codes and helpers for the timer counter unit.
// Assumes a 3-bit waveform-mode field; unlisted codes count freely.
package tmr_pkg;
    localparam int unsigned MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_UPDN_MAX = 3'd1;
    localparam logic [MODE_W-1:0] MODE_MATCH_CLR = 3'd2;
    localparam logic [MODE_W-1:0] MODE_UPDN_CMP = 3'd5;

    typedef enum logic [1:0] {
        SEQ_FREE,
        SEQ_MATCH,
        SEQ_UPDN
    } seq_kind_e;

    // Map a mode code to its sequence family.
    function automatic seq_kind_e decode_mode(input logic [MODE_W-1:0] m);
        if (m == MODE_UPDN_MAX || m == MODE_UPDN_CMP) return SEQ_UPDN;
        if (m == MODE_MATCH_CLR) return SEQ_MATCH;
        return SEQ_FREE;
    endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
// Picks one tick enable out of NSRC candidates.
// Select value 0 means stopped; value k routes source k-1.
// Assumes each source is a one-cycle pulse synchronous to clk.
module tmr_tick_sel #(
    parameter int unsigned NSRC  = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned NSLOT = 1 << SEL_W;

    logic [NSLOT-1:0] slot;

    // Slot 0 is tied low; the rest carry sources, unused slots tied low.
    assign slot[0] = 1'b0;
    for (genvar g = 1; g < NSLOT; g++) begin : g_slot
        if (g <= NSRC) begin : g_used
            assign slot[g] = src_i[g-1];
        end else begin : g_spare
            assign slot[g] = 1'b0;
        end
    end

    // Route the selected slot to the tick output.
    always_comb begin
        tick_o = slot[sel_i];
    end
endmodule

// File: rtl/tmr_seq_ctrl.sv
// Next-state logic of the counter for one tick.
// Purely combinational; the caller decides whether a tick is applied.
// Assumes dir_i is only meaningful in the up/down family.
module tmr_seq_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]      cnt_i,
    input  logic              dir_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [W-1:0]      cmp_i,
    output logic [W-1:0]      cnt_o,
    output logic              dir_o,
    output logic              wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    seq_kind_e    kind;
    logic [W-1:0] top_v;
    logic         go_down;

    // Classify the mode and pick the turning point for up/down.
    always_comb begin
        kind  = decode_mode(mode_i);
        top_v = (mode_i == MODE_UPDN_CMP) ? cmp_i : CNT_MAX;
    end

    // Compute the post-tick count, direction and wrap event.
    always_comb begin
        cnt_o   = cnt_i + CNT_ONE;
        dir_o   = 1'b0;
        wrap_o  = 1'b0;
        go_down = 1'b0;
        unique case (kind)
            SEQ_FREE: begin
                wrap_o = (cnt_i == CNT_MAX);
            end
            SEQ_MATCH: begin
                if (cnt_i == cmp_i) cnt_o = '0;
                wrap_o = (cnt_i == CNT_MAX);
            end
            SEQ_UPDN: begin
                if (cnt_i == '0 && top_v == '0) begin
                    cnt_o = '0;
                end else begin
                    go_down = dir_i ? (cnt_i != '0) : (cnt_i >= top_v);
                    cnt_o   = go_down ? (cnt_i - CNT_ONE) : (cnt_i + CNT_ONE);
                    dir_o   = go_down;
                    wrap_o  = go_down && (cnt_i == CNT_ONE);
                end
            end
            default: begin
                cnt_o = cnt_i + CNT_ONE;
            end
        endcase
    end
endmodule

// File: rtl/tmr_ovf_flag.sv
// Sticky overflow flag: set by hardware, cleared by a write of one.
// A set in the same cycle as a clear wins.
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Update the flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/tmr_count_unit.sv
// Bidirectional timer counter unit.
// Holds the count and direction, applies a selected tick through the
// sequence logic, lets a software count write override the tick, and
// keeps the overflow flag and interrupt request.
// Assumes tick sources are pulses synchronous to clk.
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned NSRC  = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   tick_src,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [MODE_W-1:0] wave_mode,
    input  logic [W-1:0]      cmp_val,
    input  logic              cpu_wr_cnt,
    input  logic [W-1:0]      cpu_wdata,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              irq_en,
    output logic [W-1:0]      cnt_out,
    output logic              at_top,
    output logic              at_bottom,
    output logic              ovf_flag,
    output logic              irq
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic         tick_act;
    logic [W-1:0] cnt_q;
    logic         dir_q;
    logic [W-1:0] nxt_cnt;
    logic         nxt_dir;
    logic         wrap_evt;
    logic         ovf_set;
    logic         updn_mode;

    tmr_tick_sel #(
        .NSRC (NSRC),
        .SEL_W(SEL_W)
    ) u_tick (
        .src_i (tick_src),
        .sel_i (clk_sel),
        .tick_o(tick_act)
    );

    tmr_seq_ctrl #(
        .W(W)
    ) u_seq (
        .cnt_i (cnt_q),
        .dir_i (dir_q),
        .mode_i(wave_mode),
        .cmp_i (cmp_val),
        .cnt_o (nxt_cnt),
        .dir_o (nxt_dir),
        .wrap_o(wrap_evt)
    );

    // A tick only counts when no software write claims the cycle.
    always_comb begin
        updn_mode = (decode_mode(wave_mode) == SEQ_UPDN);
        ovf_set   = tick_act && !cpu_wr_cnt && wrap_evt;
    end

    // Count register: software write first, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cpu_wr_cnt)      cnt_q <= cpu_wdata;
        else if (tick_act)        cnt_q <= nxt_cnt;
    end

    // Direction register: upward outside the up/down family.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= 1'b0;
        else if (!updn_mode)                 dir_q <= 1'b0;
        else if (tick_act && !cpu_wr_cnt)    dir_q <= nxt_dir;
    end

    tmr_ovf_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ovf_set),
        .clr_i (flag_wr && flag_wdata),
        .flag_o(ovf_flag)
    );

    // Status and interrupt outputs.
    always_comb begin
        cnt_out   = cnt_q;
        at_top    = (cnt_q == CNT_MAX);
        at_bottom = (cnt_q == '0);
        irq       = ovf_flag && irq_en;
    end
endmodule

// File: rtl/tmr_count_unit_chk.sv
// Property checker for tmr_count_unit, attached by bind.
// Assumes inputs change only away from the rising clock edge.
module tmr_count_unit_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   clk_sel,
    input logic [2:0]   wave_mode,
    input logic [W-1:0] cmp_val,
    input logic         cpu_wr_cnt,
    input logic [W-1:0] cpu_wdata,
    input logic         flag_wr,
    input logic         flag_wdata,
    input logic         tick_act,
    input logic         ovf_set,
    input logic [W-1:0] cnt_out,
    input logic         ovf_flag,
    input logic         irq
);
    logic free_mode;
    assign free_mode = !(wave_mode == 3'd1 || wave_mode == 3'd2 || wave_mode == 3'd5);

    p_cpu_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_cnt |=> cnt_out == $past(cpu_wdata));

    p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 && !cpu_wr_cnt) |=> $stable(cnt_out));

    p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_act && !cpu_wr_cnt && free_mode) |=> cnt_out == W'($past(cnt_out) + 1'b1));

    p_match_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_act && !cpu_wr_cnt && wave_mode == 3'd2 && cnt_out == cmp_val) |=> cnt_out == '0);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_flag);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(flag_wr && flag_wdata)) |=> ovf_flag);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);
endmodule

bind tmr_count_unit tmr_count_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .wave_mode (wave_mode),
    .cmp_val   (cmp_val),
    .cpu_wr_cnt(cpu_wr_cnt),
    .cpu_wdata (cpu_wdata),
    .flag_wr   (flag_wr),
    .flag_wdata(flag_wdata),
    .tick_act  (tick_act),
    .ovf_set   (ovf_set),
    .cnt_out   (cnt_out),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
);

// File: tb/sim_tmr_count_unit.sv
module sim_tmr_count_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] tick_src = '0;
    logic [2:0] clk_sel = '0;
    logic [2:0] wave_mode = '0;
    logic [7:0] cmp_val = '0;
    logic       cpu_wr_cnt = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] cnt_out;
    logic       at_top, at_bottom, ovf_flag, irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_cnt = '0;
    logic       m_dir = 1'b0;
    logic       m_flag = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    tmr_count_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string cnt_tag(logic [2:0] m);
        if (m == 3'd1) return "R5";
        if (m == 3'd5) return "R6";
        if (m == 3'd2) return "R4";
        return "R3";
    endfunction

    // One clock: predict from current inputs, advance, compare outputs.
    task automatic step();
        logic tk, pc, ev, dn;
        logic [7:0] nc, top;
        logic nd;
        tk = (clk_sel != 0) && tick_src[int'(clk_sel) - 1];
        pc = (wave_mode == 3'd1) || (wave_mode == 3'd5);
        top = (wave_mode == 3'd5) ? cmp_val : 8'hFF;
        nc = m_cnt; nd = m_dir; ev = 1'b0;
        if (tk) begin
            if (pc) begin
                if (m_cnt == 0 && top == 0) begin
                    nc = 0; nd = 0;
                end else begin
                    dn = m_dir ? (m_cnt != 0) : (m_cnt >= top);
                    nc = dn ? m_cnt - 8'd1 : m_cnt + 8'd1;
                    nd = dn;
                    ev = dn && (m_cnt == 8'd1);
                end
            end else begin
                ev = (m_cnt == 8'hFF);
                nc = (wave_mode == 3'd2 && m_cnt == cmp_val) ? 8'd0 : m_cnt + 8'd1;
            end
        end
        if (cpu_wr_cnt) begin
            nc = cpu_wdata; nd = m_dir; ev = 1'b0;
        end
        if (!pc) nd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_cnt = nc;
        m_dir = nd;
        if (ev) m_flag = 1'b1;
        else if (flag_wr && flag_wdata) m_flag = 1'b0;
        chk(cnt_tag(wave_mode), cnt_out, m_cnt);
        chk("R10", ovf_flag, m_flag);
        chk("R11", irq, m_flag && irq_en);
        chk("R9", {at_top, at_bottom}, {m_cnt == 8'hFF, m_cnt == 8'h00});
    endtask

    task automatic idle_inputs();
        tick_src = '0; cpu_wr_cnt = 0; flag_wr = 0; flag_wdata = 0;
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 reset cnt", cnt_out, 0);
        chk("R1 reset flag", ovf_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cnt after release", cnt_out, 0);
        chk("R1 irq after release", irq, 0);

        // Sweep every mode against every select with random traffic.
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 8; s++) begin
                wave_mode = 3'(m);
                clk_sel = 3'(s);
                cmp_val = 8'(8'h23 + m * 29 + s * 7);
                for (int c = 0; c < 300; c++) begin
                    logic [31:0] r;
                    r = rnd();
                    tick_src = r[6:0];
                    cpu_wr_cnt = (r[12:8] == 5'd0);
                    cpu_wdata = r[23:16];
                    flag_wr = (r[27:24] == 4'd0);
                    flag_wdata = r[28];
                    irq_en = r[29] | r[30];
                    step();
                end
            end
        end
        idle_inputs();

        // R2: only the selected source ticks.
        wave_mode = 3'd0; clk_sel = 3'd3;
        cpu_wr_cnt = 1; cpu_wdata = 8'h10; step(); cpu_wr_cnt = 0;
        tick_src = 7'b1111011; step();
        chk("R2 unselected sources ignored", cnt_out, 8'h10);
        tick_src = 7'b0000100; step();
        chk("R2 selected source ticks", cnt_out, 8'h11);
        clk_sel = 3'd0; tick_src = 7'h7F; step();
        chk("R2 stopped holds", cnt_out, 8'h11);

        // R8: write beats a wrapping tick, no flag.
        flag_wr = 1; flag_wdata = 1; step(); flag_wr = 0; flag_wdata = 0;
        clk_sel = 3'd1; tick_src = 0;
        cpu_wr_cnt = 1; cpu_wdata = 8'hFF; step();
        tick_src = 7'h01; cpu_wdata = 8'h40; step(); cpu_wr_cnt = 0;
        chk("R8 write wins over tick", cnt_out, 8'h40);
        chk("R8 discarded tick sets no flag", ovf_flag, 0);

        // R3: wrap sets flag; R10 set beats clear in same cycle.
        tick_src = 0; cpu_wr_cnt = 1; cpu_wdata = 8'hFF; step(); cpu_wr_cnt = 0;
        tick_src = 7'h01; flag_wr = 1; flag_wdata = 1; step();
        flag_wr = 0; flag_wdata = 0; tick_src = 0;
        chk("R3 wrap to zero", cnt_out, 0);
        chk("R10 set wins over clear", ovf_flag, 1);
        flag_wr = 1; flag_wdata = 0; step();
        chk("R10 write of zero ignored", ovf_flag, 1);
        irq_en = 1; flag_wdata = 1; step(); flag_wr = 0; flag_wdata = 0;
        chk("R10 write of one clears", ovf_flag, 0);
        chk("R11 irq follows flag", irq, 0);

        // R5/R7: turn at top, reach bottom going down sets flag.
        wave_mode = 3'd1;
        cpu_wr_cnt = 1; cpu_wdata = 8'hFE; step(); cpu_wr_cnt = 0;
        tick_src = 7'h01; step(); step();
        chk("R5 turn at top", cnt_out, 8'hFE);
        tick_src = 0; cpu_wr_cnt = 1; cpu_wdata = 8'h01; step(); cpu_wr_cnt = 0;
        tick_src = 7'h01; step();
        chk("R7 down to bottom", cnt_out, 0);
        chk("R7 flag at bottom", ovf_flag, 1);
        chk("R11 irq raised", irq, 1);
        step();
        chk("R5 turn at bottom", cnt_out, 8'h01);

        // R6: programmable top of zero holds at zero.
        wave_mode = 3'd5; cmp_val = 8'h00; tick_src = 0;
        cpu_wr_cnt = 1; cpu_wdata = 8'h00; step(); cpu_wr_cnt = 0;
        tick_src = 7'h01; repeat (4) step();
        chk("R6 zero top holds", cnt_out, 0);

        // R4: match clears on the tick after equality.
        wave_mode = 3'd2; cmp_val = 8'h05; tick_src = 0;
        cpu_wr_cnt = 1; cpu_wdata = 8'h04; step(); cpu_wr_cnt = 0;
        tick_src = 7'h01; step();
        chk("R4 reach match", cnt_out, 8'h05);
        step();
        chk("R4 clear on match", cnt_out, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule